// File: doc/BRIEF.md
# Protected-Mode System Register File

This block keeps the processor state that protected-mode execution depends on: the global and interrupt descriptor-table registers (each a 32-bit base and a 16-bit limit), the local-table selector and the task-register selector (each with a hidden descriptor cache), and a 32-bit control register whose bit 0 enables protection. An upstream decoder presents one already-decoded operation per cycle together with a 48-bit operand. The block executes register loads, register stores and control-register moves. It returns store results or an exception vector one cycle later.

Loading the local-table or task-register selector starts a descriptor read from the global table over a simple request/valid port. The block first checks the selector against the global-table limit. It then holds the request until the data returns, unpacks base, limit and attribute bits into the hidden cache, and exposes the cached values to the address logic. While a read is outstanding, `busy` is high and new operations are dropped.

Top module: `pm_sysreg_file`

## Requirements
- R1: After synchronous reset every register and the descriptor caches are zero, `pe`, `busy`, `rd_valid`, `exc_valid` and `gdt_rd_req` are low, and a store of the global-table register returns zero.
- R2: An operation is accepted when `op_valid` is high and `busy` is low. Code 1 loads the global-table register from `op_data` and code 3 loads the interrupt-table register. Codes 2 and 4 store them. A store returns the base in bits 47:16 and the limit in bits 15:0, with `rd_valid` high in the cycle after acceptance.
- R3: Code 11 writes the control register from `op_data[31:0]` and code 12 reads it back zero-extended. Only bits 0,1,2,3,4,5,16,18,29,30,31 are kept (PE is bit 0). All other bits read as zero. This move can set or clear PE, and `pe` follows bit 0.
- R4: Code 9, the legacy status-word write, changes only bits 3:0. Bits 3:1 take the written value, and the new PE is the old PE OR written bit 0, so this operation never clears PE.
- R5: Code 10 returns control-register bits 15:0 zero-extended on `rd_data`.
- R6: While PE is 0, codes 5, 6, 7 and 8 (local-table load/store, task-register load/store) raise `exc_valid` with vector 6 in the next cycle. They return no data and change no register.
- R7: An in-range load (code 5 or 7 with PE set) raises `busy` and `gdt_rd_req` from the next cycle on. The request address is global base + selector with bits 2:0 cleared, and the request and address stay steady until `gdt_rd_valid`.
- R8: A load whose selector, with bits 2:0 forced to 1, exceeds the global-table limit raises vector 13 in the next cycle. It issues no read and leaves the selector and cache unchanged.
- R9: In the cycle `gdt_rd_valid` arrives during a read, the selector is written and the cache is filled. Base comes from descriptor bits 63:56 and 39:16, limit from bits 51:48 and 15:0, and attributes from bits 47:40. `busy` falls after that same edge.
- R10: An operation presented while `busy` is high is ignored: it changes no register and produces neither data nor an exception.
- R11: Codes 6 and 8 with PE set return the local-table or task selector in bits 15:0, zero-extended.
- R12: Code 0 and unused codes 13 to 15 change nothing and produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present |
| op_code | input | 4 | Decoded operation code |
| op_data | input | 48 | Operand for loads and moves |
| busy | output | 1 | Descriptor read in progress |
| rd_valid | output | 1 | Store result valid |
| rd_data | output | 48 | Store result |
| exc_valid | output | 1 | Exception raised |
| exc_vector | output | 8 | Exception vector number |
| pe | output | 1 | Protection enabled |
| gdt_rd_req | output | 1 | Descriptor read request |
| gdt_rd_addr | output | 32 | Descriptor read address |
| gdt_rd_valid | input | 1 | Descriptor read data valid |
| gdt_rd_data | input | 64 | Descriptor read data |
| ldtr_base | output | 32 | Cached local-table base |
| ldtr_limit | output | 20 | Cached local-table limit |
| ldtr_attr | output | 8 | Cached local-table attributes |
| tr_base | output | 32 | Cached task-segment base |
| tr_limit | output | 20 | Cached task-segment limit |
| tr_attr | output | 8 | Cached task-segment attributes |

## Verification
The control register receives all-ones, all-zeros and partial status-word patterns. Comparing the two write paths separates the sticky PE behaviour from the full move, and the all-ones pattern exposes any unmasked reserved bit. Selector loads are tried at the exact table-limit boundary and one entry past it, which separates an off-by-one limit test from a correct one. Local-table operations are issued both before PE is set and after PE is cleared again. An operation is also driven during an outstanding descriptor read to show it has no effect. Descriptors whose address is folded into every field reveal a wrong fetch address or a wrong unpacking of the split base and limit.

// File: rtl/pmsr_pkg.sv
package pmsr_pkg;
    localparam int OP_W     = 4;
    localparam int SEL_W    = 16;
    localparam int BASE_W   = 32;
    localparam int LIM_W    = 16;
    localparam int DATA_W   = BASE_W + LIM_W;
    localparam int CR_W     = 32;
    localparam int SEGLIM_W = 20;
    localparam int ATTR_W   = 8;
    localparam int DESC_W   = 64;
    localparam int VEC_W    = 8;
    localparam int NSEG     = 2;
    localparam int SEG_LDT  = 0;
    localparam int SEG_TR   = 1;
    localparam int IDX_LSB  = 3;

    localparam logic [CR_W-1:0]  CR_KEEP = 32'hE005_003F;
    localparam logic [VEC_W-1:0] VEC_UD  = 8'd6;
    localparam logic [VEC_W-1:0] VEC_GP  = 8'd13;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 4'd0,
        OP_GDT_LD = 4'd1,
        OP_GDT_ST = 4'd2,
        OP_IDT_LD = 4'd3,
        OP_IDT_ST = 4'd4,
        OP_LDT_LD = 4'd5,
        OP_LDT_ST = 4'd6,
        OP_TR_LD  = 4'd7,
        OP_TR_ST  = 4'd8,
        OP_MSW_LD = 4'd9,
        OP_MSW_ST = 4'd10,
        OP_CR_LD  = 4'd11,
        OP_CR_ST  = 4'd12
    } sr_op_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LIM_W-1:0]  limit;
    } tbl_reg_t;

    typedef struct packed {
        logic [BASE_W-1:0]   base;
        logic [SEGLIM_W-1:0] limit;
        logic [ATTR_W-1:0]   attr;
    } seg_cache_t;

    function automatic seg_cache_t desc_unpack(input logic [DESC_W-1:0] d);
        seg_cache_t c;
        c.base  = {d[63:56], d[39:16]};
        c.limit = {d[51:48], d[15:0]};
        c.attr  = d[47:40];
        return c;
    endfunction

    function automatic logic sel_fits(input logic [SEL_W-1:0] sel,
                                      input logic [LIM_W-1:0] lim);
        return {sel[SEL_W-1:IDX_LSB], {IDX_LSB{1'b1}}} <= lim;
    endfunction

    function automatic logic [BASE_W-1:0] desc_addr(input logic [BASE_W-1:0] base,
                                                    input logic [SEL_W-1:0] sel);
        return base + {{(BASE_W-SEL_W){1'b0}}, sel[SEL_W-1:IDX_LSB], {IDX_LSB{1'b0}}};
    endfunction

    function automatic logic is_local_op(input sr_op_e op);
        return (op == OP_LDT_LD) || (op == OP_LDT_ST) ||
               (op == OP_TR_LD)  || (op == OP_TR_ST);
    endfunction
endpackage

// File: rtl/pmsr_ctrl_reg.sv
module pmsr_ctrl_reg
    import pmsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_full,
    input  logic            wr_legacy,
    input  logic [CR_W-1:0] wdata,
    output logic [CR_W-1:0] cr
);
    always_ff @(posedge clk) begin
        if (rst)
            cr <= '0;
        else if (wr_full)
            cr <= wdata & CR_KEEP;
        else if (wr_legacy)
            cr <= {cr[CR_W-1:4], wdata[3:1], cr[0] | wdata[0]};
    end

    // status-word path may set protection but must not drop it
    p_pe_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_legacy && !wr_full && cr[0]) |=> cr[0]);
endmodule

// File: rtl/pmsr_seg_slot.sv
module pmsr_seg_slot
    import pmsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SEL_W-1:0] sel_in,
    input  seg_cache_t       cache_in,
    output logic [SEL_W-1:0] sel,
    output seg_cache_t       cache
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel   <= '0;
            cache <= '0;
        end else if (load) begin
            sel   <= sel_in;
            cache <= cache_in;
        end
    end
endmodule

// File: rtl/pmsr_desc_fetch.sv
module pmsr_desc_fetch
    import pmsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SEL_W-1:0]  start_sel,
    input  logic              start_tgt,
    input  logic [BASE_W-1:0] gdt_base,
    input  logic              gdt_rd_valid,
    input  logic [DESC_W-1:0] gdt_rd_data,
    output logic              busy,
    output logic              gdt_rd_req,
    output logic [BASE_W-1:0] gdt_rd_addr,
    output logic [NSEG-1:0]   commit,
    output logic [SEL_W-1:0]  commit_sel,
    output seg_cache_t        commit_cache
);
    typedef enum logic {F_IDLE, F_WAIT} fst_e;
    fst_e              st;
    logic [BASE_W-1:0] addr_q;
    logic [SEL_W-1:0]  sel_q;
    logic              tgt_q;
    logic              done;

    assign done = (st == F_WAIT) && gdt_rd_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= F_IDLE;
            addr_q <= '0;
            sel_q  <= '0;
            tgt_q  <= 1'b0;
        end else if (st == F_IDLE) begin
            if (start) begin
                st     <= F_WAIT;
                addr_q <= desc_addr(gdt_base, start_sel);
                sel_q  <= start_sel;
                tgt_q  <= start_tgt;
            end
        end else if (done) begin
            st <= F_IDLE;
        end
    end

    for (genvar i = 0; i < NSEG; i++) begin : g_commit
        assign commit[i] = done && (tgt_q == 1'(i));
    end

    assign busy         = (st == F_WAIT);
    assign gdt_rd_req   = (st == F_WAIT);
    assign gdt_rd_addr  = addr_q;
    assign commit_sel   = sel_q;
    assign commit_cache = desc_unpack(gdt_rd_data);

    p_commit_one_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && gdt_rd_valid) |=> !busy);
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (gdt_rd_req && !gdt_rd_valid) |=> (gdt_rd_req && $stable(gdt_rd_addr)));
endmodule

// File: rtl/pm_sysreg_file.sv
module pm_sysreg_file
    import pmsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [OP_W-1:0]     op_code,
    input  logic [DATA_W-1:0]   op_data,
    output logic                busy,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data,
    output logic                exc_valid,
    output logic [VEC_W-1:0]    exc_vector,
    output logic                pe,
    output logic                gdt_rd_req,
    output logic [BASE_W-1:0]   gdt_rd_addr,
    input  logic                gdt_rd_valid,
    input  logic [DESC_W-1:0]   gdt_rd_data,
    output logic [BASE_W-1:0]   ldtr_base,
    output logic [SEGLIM_W-1:0] ldtr_limit,
    output logic [ATTR_W-1:0]   ldtr_attr,
    output logic [BASE_W-1:0]   tr_base,
    output logic [SEGLIM_W-1:0] tr_limit,
    output logic [ATTR_W-1:0]   tr_attr
);
    sr_op_e            op;
    logic              acc, is_load, ud, gp, start, store;
    tbl_reg_t          gdtr, idtr;
    logic [CR_W-1:0]   cr;
    logic [SEL_W-1:0]  seg_sel   [NSEG];
    seg_cache_t        seg_cache [NSEG];
    logic [NSEG-1:0]   commit;
    logic [SEL_W-1:0]  commit_sel;
    seg_cache_t        commit_cache;
    logic [DATA_W-1:0] rd_next;

    assign op      = sr_op_e'(op_code);
    assign acc     = op_valid && !busy;
    assign pe      = cr[0];
    assign is_load = (op == OP_LDT_LD) || (op == OP_TR_LD);
    assign ud      = acc && is_local_op(op) && !pe;
    assign gp      = acc && is_load && pe && !sel_fits(op_data[SEL_W-1:0], gdtr.limit);
    assign start   = acc && is_load && pe && !gp;

    always_ff @(posedge clk) begin
        if (rst) begin
            gdtr <= '0;
            idtr <= '0;
        end else if (acc) begin
            if (op == OP_GDT_LD) gdtr <= op_data;
            if (op == OP_IDT_LD) idtr <= op_data;
        end
    end

    pmsr_ctrl_reg u_cr (
        .clk       (clk),
        .rst       (rst),
        .wr_full   (acc && op == OP_CR_LD),
        .wr_legacy (acc && op == OP_MSW_LD),
        .wdata     (op_data[CR_W-1:0]),
        .cr        (cr)
    );

    pmsr_desc_fetch u_fetch (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_sel    (op_data[SEL_W-1:0]),
        .start_tgt    (op == OP_TR_LD),
        .gdt_base     (gdtr.base),
        .gdt_rd_valid (gdt_rd_valid),
        .gdt_rd_data  (gdt_rd_data),
        .busy         (busy),
        .gdt_rd_req   (gdt_rd_req),
        .gdt_rd_addr  (gdt_rd_addr),
        .commit       (commit),
        .commit_sel   (commit_sel),
        .commit_cache (commit_cache)
    );

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        pmsr_seg_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .load     (commit[i]),
            .sel_in   (commit_sel),
            .cache_in (commit_cache),
            .sel      (seg_sel[i]),
            .cache    (seg_cache[i])
        );
    end

    always_comb begin
        store   = 1'b1;
        rd_next = '0;
        case (op)
            OP_GDT_ST: rd_next = gdtr;
            OP_IDT_ST: rd_next = idtr;
            OP_LDT_ST: rd_next = DATA_W'(seg_sel[SEG_LDT]);
            OP_TR_ST:  rd_next = DATA_W'(seg_sel[SEG_TR]);
            OP_MSW_ST: rd_next = DATA_W'(cr[15:0]);
            OP_CR_ST:  rd_next = DATA_W'(cr);
            default:   store   = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            exc_valid  <= 1'b0;
            exc_vector <= '0;
        end else begin
            rd_valid  <= acc && store && !ud;
            exc_valid <= ud || gp;
            if (acc && store && !ud) rd_data <= rd_next;
            if (ud)      exc_vector <= VEC_UD;
            else if (gp) exc_vector <= VEC_GP;
        end
    end

    assign ldtr_base  = seg_cache[SEG_LDT].base;
    assign ldtr_limit = seg_cache[SEG_LDT].limit;
    assign ldtr_attr  = seg_cache[SEG_LDT].attr;
    assign tr_base    = seg_cache[SEG_TR].base;
    assign tr_limit   = seg_cache[SEG_TR].limit;
    assign tr_attr    = seg_cache[SEG_TR].attr;

    p_ud_raise_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && is_local_op(op) && !pe)
            |=> (exc_valid && exc_vector == VEC_UD && !rd_valid && !busy));
    p_gp_noupd_r8: assert property (@(posedge clk) disable iff (rst)
        gp |=> (exc_valid && exc_vector == VEC_GP && !busy
                && $stable(seg_sel[SEG_LDT]) && $stable(seg_sel[SEG_TR])));
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && busy) |=> (!exc_valid && !rd_valid));
    p_one_resp_r2: assert property (@(posedge clk) disable iff (rst)
        !(exc_valid && rd_valid));
endmodule

// File: tb/tb_pm_sysreg_file.sv
module tb_pm_sysreg_file;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [47:0] op_data;
    logic        busy, rd_valid, exc_valid, pe, gdt_rd_req;
    logic [47:0] rd_data;
    logic [7:0]  exc_vector, ldtr_attr, tr_attr;
    logic [31:0] gdt_rd_addr, ldtr_base, tr_base;
    logic        gdt_rd_valid;
    logic [63:0] gdt_rd_data;
    logic [19:0] ldtr_limit, tr_limit;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pm_sysreg_file dut (.*);

    function automatic logic [63:0] mk_desc(input logic [31:0] a);
        logic [31:0] b;
        logic [19:0] l;
        b = 32'hA000_0000 | a;
        l = 20'h5_0000 | {4'h0, a[15:0]};
        return {b[31:24], 4'h0, l[19:16], 8'h82, b[23:0], l[15:0]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            gdt_rd_valid <= 1'b0;
            gdt_rd_data  <= '0;
        end else begin
            gdt_rd_valid <= gdt_rd_req && !gdt_rd_valid;
            gdt_rd_data  <= mk_desc(gdt_rd_addr);
        end
    end

    typedef struct packed {
        logic [3:0]  op;
        logic [47:0] data;
        logic        exc;
        logic [7:0]  vec;
        logic        rdv;
        logic [47:0] rd;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{4'd6,  48'h0,              1'b1, 8'd6,  1'b0, 48'h0},              // R6
        '{4'd7,  48'h10,             1'b1, 8'd6,  1'b0, 48'h0},              // R6
        '{4'd1,  48'h0000_1000_001F, 1'b0, 8'd0,  1'b0, 48'h0},              // R2
        '{4'd2,  48'h0,              1'b0, 8'd0,  1'b1, 48'h0000_1000_001F}, // R2
        '{4'd3,  48'h0000_2000_07FF, 1'b0, 8'd0,  1'b0, 48'h0},              // R2
        '{4'd4,  48'h0,              1'b0, 8'd0,  1'b1, 48'h0000_2000_07FF}, // R2
        '{4'd9,  48'hFFFF_FFFF_FFFE, 1'b0, 8'd0,  1'b0, 48'h0},              // R4
        '{4'd10, 48'h0,              1'b0, 8'd0,  1'b1, 48'hE},              // R5
        '{4'd9,  48'hF,              1'b0, 8'd0,  1'b0, 48'h0},              // R4
        '{4'd10, 48'h0,              1'b0, 8'd0,  1'b1, 48'hF},              // R5
        '{4'd9,  48'h0,              1'b0, 8'd0,  1'b0, 48'h0},              // R4
        '{4'd10, 48'h0,              1'b0, 8'd0,  1'b1, 48'h1},              // R4 sticky PE
        '{4'd11, 48'hFFFF_FFFF_FFFF, 1'b0, 8'd0,  1'b0, 48'h0},              // R3
        '{4'd12, 48'h0,              1'b0, 8'd0,  1'b1, 48'hE005_003F},      // R3
        '{4'd10, 48'h0,              1'b0, 8'd0,  1'b1, 48'h003F},           // R5
        '{4'd11, 48'h0,              1'b0, 8'd0,  1'b0, 48'h0},              // R3
        '{4'd12, 48'h0,              1'b0, 8'd0,  1'b1, 48'h0},              // R3
        '{4'd6,  48'h0,              1'b1, 8'd6,  1'b0, 48'h0},              // R6
        '{4'd11, 48'h1,              1'b0, 8'd0,  1'b0, 48'h0},              // R3
        '{4'd5,  48'h20,             1'b1, 8'd13, 1'b0, 48'h0},              // R8
        '{4'd6,  48'h0,              1'b0, 8'd0,  1'b1, 48'h0},              // R11
        '{4'd5,  48'h1B,             1'b0, 8'd0,  1'b0, 48'h0},              // R7
        '{4'd6,  48'h0,              1'b0, 8'd0,  1'b1, 48'h1B},             // R11
        '{4'd7,  48'h8,              1'b0, 8'd0,  1'b0, 48'h0},              // R7
        '{4'd8,  48'h0,              1'b0, 8'd0,  1'b1, 48'h8},              // R11
        '{4'd7,  48'h28,             1'b1, 8'd13, 1'b0, 48'h0},              // R8
        '{4'd8,  48'h0,              1'b0, 8'd0,  1'b1, 48'h8},              // R8
        '{4'd15, 48'hFFFF_FFFF_FFFF, 1'b0, 8'd0,  1'b0, 48'h0}               // R12
    };

    function automatic string req_of(input vec_t v);
        if (v.exc && v.vec == 8'd6)  return "R6";
        if (v.exc && v.vec == 8'd13) return "R8";
        case (v.op)
            4'd1, 4'd2, 4'd3, 4'd4: return "R2";
            4'd5, 4'd7:             return "R7";
            4'd6, 4'd8:             return "R11";
            4'd9:                   return "R4";
            4'd10:                  return "R5";
            4'd11, 4'd12:           return "R3";
            default:                return "R12";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    logic        s_exc, s_rdv;
    logic [7:0]  s_vec;
    logic [47:0] s_rd;

    task automatic do_op(input logic [3:0] c, input logic [47:0] d);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = c;
        op_data  = d;
        @(negedge clk);
        s_exc = exc_valid;
        s_vec = exc_vector;
        s_rdv = rd_valid;
        s_rd  = rd_data;
        op_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        op_valid = 1'b0;
        op_code = '0;
        op_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!pe && !busy && !rd_valid && !exc_valid && !gdt_rd_req, "R1", "idle flags",
              {59'b0, pe, busy, rd_valid, exc_valid, gdt_rd_req}, 64'h0);
        check(ldtr_base == 0 && tr_base == 0 && ldtr_limit == 0, "R1", "cache zero",
              {32'b0, ldtr_base}, 64'h0);
        do_op(4'd2, 48'h0);
        check(s_rdv && s_rd == 48'h0, "R1", "gdtr reset", {15'b0, s_rdv, s_rd}, 64'h1_0000_0000_0000);

        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].op, VECS[i].data);
            check(s_exc == VECS[i].exc && s_rdv == VECS[i].rdv
                  && (!s_exc || s_vec == VECS[i].vec) && (!s_rdv || s_rd == VECS[i].rd),
                  req_of(VECS[i]), $sformatf("vector %0d", i),
                  {6'b0, s_exc, s_vec, s_rdv, s_rd},
                  {6'b0, VECS[i].exc, VECS[i].vec, VECS[i].rdv, VECS[i].rd});
        end

        // R9 cache contents from the fetch at 0x1018 and 0x1008
        check(ldtr_base == 32'hA000_1018 && ldtr_limit == 20'h5_1018 && ldtr_attr == 8'h82,
              "R9", "ldtr cache", {ldtr_base, 4'b0, ldtr_limit, ldtr_attr},
              {32'hA000_1018, 4'b0, 20'h5_1018, 8'h82});
        check(tr_base == 32'hA000_1008 && tr_limit == 20'h5_1008 && tr_attr == 8'h82,
              "R9", "tr cache", {tr_base, 4'b0, tr_limit, tr_attr},
              {32'hA000_1008, 4'b0, 20'h5_1008, 8'h82});

        // R7 fetch address and hold; R10 op ignored while busy
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = 4'd7;
        op_data  = 48'h13;
        @(negedge clk);
        check(busy && gdt_rd_req && gdt_rd_addr == 32'h1010, "R7", "request",
              {30'b0, busy, gdt_rd_req, gdt_rd_addr}, {30'b0, 2'b11, 32'h1010});
        op_code = 4'd1;
        op_data = 48'h0000_9999_0007;
        @(negedge clk);
        check(!rd_valid && !exc_valid, "R10", "no response while busy",
              {62'b0, rd_valid, exc_valid}, 64'h0);
        op_valid = 1'b0;
        while (busy) @(negedge clk);
        check(tr_base == 32'hA000_1010, "R9", "tr base after fetch", {32'b0, tr_base},
              64'hA000_1010);
        do_op(4'd2, 48'h0);
        check(s_rd == 48'h0000_1000_001F, "R10", "gdtr unchanged", {16'b0, s_rd},
              64'h0000_1000_001F);
        do_op(4'd8, 48'h0);
        check(s_rd == 48'h13, "R11", "tr selector", {16'b0, s_rd}, 64'h13);

        // R8 limit boundary also leaves cache untouched
        do_op(4'd5, 48'h20);
        check(ldtr_base == 32'hA000_1018 && !gdt_rd_req, "R8", "cache after fault",
              {32'b0, ldtr_base}, 64'hA000_1018);

        // R12 reserved code leaves control register unchanged
        do_op(4'd13, 48'hFFFF_FFFF_FFFF);
        do_op(4'd12, 48'h0);
        check(s_rd == 48'h1 && pe, "R12", "cr after unused code", {16'b0, s_rd}, 64'h1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule